// File: doc/BRIEF.md
# Two-Coin Vending Controller with Jam Lockout

This block sequences a small drink vending machine. It collects a fixed number of quarter deposits (two by default). Once fully paid, it accepts one product selection out of three and issues a single-cycle dispense strobe on the line for that product. It then holds until the customer removes the bottle, and only after that does it take money again. Every input is a single-cycle pulse, sampled on the rising clock edge.

A stuck-bottle indicator overrides all normal operation. From any normal state the controller moves into a lockout state. In lockout the coin slot is closed and nothing is issued until a clear pulse arrives. Any partial or full credit held when the jam is reported is forfeited. The coin-accept output tells the slot mechanism when quarters may be taken. A 3-bit status code reports where the sequence stands.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is held and directly after it, status is 0 (idle), coin-accept is 1 and all dispense lines are 0.
- R2: With COINS_NEEDED=2, a quarter in idle moves status to 1 (partial credit), and a quarter in partial credit moves it to 2 (paid). Each move is visible one cycle after the pulse.
- R3: Coin-accept is 1 exactly when status is 0 or 1, and 0 in every other status.
- R4: In status 2, a selection moves status to 3 (vending). On the next cycle it raises the matching dispense line: bit 0 for cola, bit 1 for diet cola, bit 2 for lemon-lime.
- R5: When several selections arrive in the same cycle, only one dispense line rises. Cola wins over diet cola, and diet cola wins over lemon-lime.
- R6: A selection in any status other than 2 raises no dispense line and leaves status unchanged.
- R7: In status 3, status stays at 3 and quarters are ignored until a bottle-taken pulse, which returns status to 0.
- R8: A stuck pulse in any status other than 4 moves status to 4 (jammed) on the next cycle. It overrides quarters, selections, bottle-taken and clear arriving in the same cycle.
- R9: In status 4, quarters, selections and bottle-taken have no effect: status stays 4, coin-accept is 0 and no dispense line rises.
- R10: A clear pulse in status 4 returns status to 0, and any credit held before the jam is lost, so one later quarter gives status 1, not 2.
- R11: A clear pulse outside status 4 has no effect.
- R12: Each dispense strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coin_i | input | 1 | Quarter deposited (one-cycle pulse) |
| sel_i | input | NUM_PROD | Selection buttons: bit 0 cola, bit 1 diet cola, bit 2 lemon-lime |
| taken_i | input | 1 | Bottle removed by customer |
| stuck_i | input | 1 | Stuck-bottle indicator pulse |
| cleared_i | input | 1 | Jam cleared pulse |
| dispense_o | output | NUM_PROD | One-cycle dispense strobe per product |
| coin_en_o | output | 1 | Coin slot may accept quarters |
| status_o | output | 3 | 0 idle, 1 partial credit, 2 paid, 3 vending, 4 jammed |

## Verification
The bench builds the block with COINS_NEEDED=2 and NUM_PROD=3. At this size, all five status values can be reached within a few cycles of reset. From each of those start points it applies every one of the 128 combinations of the seven input pulses. The expected status, strobe and coin-accept values come from an arithmetic reference of the rules. That reference covers every priority clash, such as a jam arriving together with a selection. Directed sequences add the loss of credit across a jam and the bottle-taken wait.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int STAT_W = 3;

    localparam logic [STAT_W-1:0] STAT_IDLE = 3'd0;
    localparam logic [STAT_W-1:0] STAT_PART = 3'd1;
    localparam logic [STAT_W-1:0] STAT_PAID = 3'd2;
    localparam logic [STAT_W-1:0] STAT_VEND = 3'd3;
    localparam logic [STAT_W-1:0] STAT_JAM  = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PART,
        S_PAID,
        S_VEND,
        S_JAM
    } vstate_e;

    function automatic logic [STAT_W-1:0] to_status(vstate_e s);
        case (s)
            S_IDLE:  return STAT_IDLE;
            S_PART:  return STAT_PART;
            S_PAID:  return STAT_PAID;
            S_VEND:  return STAT_VEND;
            default: return STAT_JAM;
        endcase
    endfunction

    function automatic logic slot_open(vstate_e s);
        return (s == S_IDLE) || (s == S_PART);
    endfunction

endpackage

// File: rtl/vend_select_arb.sv
module vend_select_arb #(
    parameter int NUM_PROD = 3
) (
    input  logic [NUM_PROD-1:0] sel_i,
    output logic                valid_o,
    output logic [NUM_PROD-1:0] pick_o
);
    logic [NUM_PROD:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_PROD; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | sel_i[i];
        assign pick_o[i]  = sel_i[i] & ~seen[i];
    end

    assign valid_o = seen[NUM_PROD];
endmodule

// File: rtl/vend_credit.sv
module vend_credit #(
    parameter int COINS_NEEDED = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = (COINS_NEEDED > 1) ? $clog2(COINS_NEEDED + 1) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last_o = (cnt_q == CW'(COINS_NEEDED - 1));
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int COINS_NEEDED = 2,
    parameter int NUM_PROD     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_i,
    input  logic [NUM_PROD-1:0] sel_i,
    input  logic                taken_i,
    input  logic                stuck_i,
    input  logic                cleared_i,
    output logic [NUM_PROD-1:0] dispense_o,
    output logic                coin_en_o,
    output logic [2:0]          status_o
);
    vstate_e             state_q, state_d;
    logic [NUM_PROD-1:0] disp_q;
    logic [NUM_PROD-1:0] pick;
    logic                pick_valid;
    logic                credit_last;
    logic                credit_inc;
    logic                credit_clr;
    logic                fire;

    vend_select_arb #(.NUM_PROD(NUM_PROD)) u_arb (
        .sel_i   (sel_i),
        .valid_o (pick_valid),
        .pick_o  (pick)
    );

    vend_credit #(.COINS_NEEDED(COINS_NEEDED)) u_credit (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (credit_clr),
        .inc_i  (credit_inc),
        .last_o (credit_last)
    );

    always_comb begin
        state_d    = state_q;
        credit_inc = 1'b0;
        credit_clr = 1'b0;
        fire       = 1'b0;
        if (stuck_i && state_q != S_JAM) begin
            state_d    = S_JAM;
            credit_clr = 1'b1;
        end else begin
            case (state_q)
                S_IDLE, S_PART: begin
                    if (coin_i) begin
                        if (credit_last) begin
                            state_d    = S_PAID;
                            credit_clr = 1'b1;
                        end else begin
                            state_d    = S_PART;
                            credit_inc = 1'b1;
                        end
                    end
                end
                S_PAID: begin
                    if (pick_valid) begin
                        state_d = S_VEND;
                        fire    = 1'b1;
                    end
                end
                S_VEND: begin
                    if (taken_i) state_d = S_IDLE;
                end
                S_JAM: begin
                    if (cleared_i) begin
                        state_d    = S_IDLE;
                        credit_clr = 1'b1;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            disp_q  <= '0;
        end else begin
            state_q <= state_d;
            disp_q  <= fire ? pick : '0;
        end
    end

    assign dispense_o = disp_q;
    assign coin_en_o  = slot_open(state_q);
    assign status_o   = to_status(state_q);
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
#(
    parameter int NUM_PROD = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                coin_i,
    input logic [NUM_PROD-1:0] sel_i,
    input logic                taken_i,
    input logic                stuck_i,
    input logic                cleared_i,
    input logic [NUM_PROD-1:0] dispense_o,
    input logic                coin_en_o,
    input logic [2:0]          status_o
);
    AST_DISP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dispense_o)); // R5

    AST_DISP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|dispense_o) |=> (dispense_o == '0)); // R12

    AST_SEL_ONLY_PAID: assert property (@(posedge clk) disable iff (rst)
        (status_o != STAT_PAID) |=> (dispense_o == '0)); // R6

    AST_PAID_FIRES: assert property (@(posedge clk) disable iff (rst)
        (status_o == STAT_PAID && (|sel_i) && !stuck_i)
        |=> ((|dispense_o) && status_o == STAT_VEND)); // R4

    AST_COIN_EN: assert property (@(posedge clk) disable iff (rst)
        coin_en_o == (status_o == STAT_IDLE || status_o == STAT_PART)); // R3

    AST_COIN_ADV: assert property (@(posedge clk) disable iff (rst)
        (status_o == STAT_IDLE && coin_i && !stuck_i)
        |=> (status_o == STAT_PART || status_o == STAT_PAID)); // R2

    AST_TAKE_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (status_o == STAT_VEND && taken_i && !stuck_i)
        |=> (status_o == STAT_IDLE)); // R7

    AST_JAM_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (stuck_i && status_o != STAT_JAM) |=> (status_o == STAT_JAM)); // R8

    AST_JAM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (status_o == STAT_JAM && !cleared_i) |=> (status_o == STAT_JAM)); // R9

    AST_JAM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (status_o == STAT_JAM && cleared_i) |=> (status_o == STAT_IDLE)); // R10
endmodule

bind vend_ctrl vend_ctrl_chk #(.NUM_PROD(NUM_PROD)) u_chk (.*);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_i = 1'b0;
    logic [2:0] sel_i = 3'b000;
    logic       taken_i = 1'b0;
    logic       stuck_i = 1'b0;
    logic       cleared_i = 1'b0;
    logic [2:0] dispense_o;
    logic       coin_en_o;
    logic [2:0] status_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    vend_ctrl #(.COINS_NEEDED(2), .NUM_PROD(3)) dut (
        .clk(clk), .rst(rst), .coin_i(coin_i), .sel_i(sel_i),
        .taken_i(taken_i), .stuck_i(stuck_i), .cleared_i(cleared_i),
        .dispense_o(dispense_o), .coin_en_o(coin_en_o), .status_o(status_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [2:0] sl, input logic tk,
                         input logic st, input logic cl);
        coin_i = c; sel_i = sl; taken_i = tk; stuck_i = st; cleared_i = cl;
        @(posedge clk);
        @(negedge clk);
        coin_i = 1'b0; sel_i = 3'b000; taken_i = 1'b0; stuck_i = 1'b0; cleared_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic goto_state(input int s);
        do_reset();
        case (s)
            1: drive(1, 0, 0, 0, 0);
            2: begin drive(1, 0, 0, 0, 0); drive(1, 0, 0, 0, 0); end
            3: begin drive(1, 0, 0, 0, 0); drive(1, 0, 0, 0, 0); drive(0, 3'b001, 0, 0, 0); end
            4: drive(0, 0, 0, 1, 0);
            default: ;
        endcase
    endtask

    // Reference built from the requirement list (statuses 0..4).
    task automatic model(input int s, input logic c, input logic [2:0] sl,
                         input logic tk, input logic st, input logic cl,
                         output int ns, output int d, output string tag);
        ns = s; d = 0; tag = "R2";
        if (st && s != 4) begin
            ns = 4; tag = "R8";
        end else begin
            case (s)
                0, 1: begin
                    if (c) ns = s + 1;
                    if (sl != 0) tag = "R6";
                    else if (cl) tag = "R11";
                end
                2: begin
                    if (sl != 0) begin
                        ns = 3;
                        d = sl[0] ? 1 : (sl[1] ? 2 : 4);
                        tag = ($countones(sl) > 1) ? "R5" : "R4";
                    end else if (cl) tag = "R11";
                end
                3: begin
                    if (tk) ns = 0;
                    tag = (sl != 0) ? "R6" : "R7";
                end
                default: begin
                    if (cl) begin ns = 0; tag = "R10"; end
                    else tag = "R9";
                end
            endcase
        end
    endtask

    initial begin
        int ns, d;
        string tag;
        @(negedge clk);
        // R1 during and after reset
        drive(0, 0, 0, 0, 0);
        check("R1 status in reset", int'(status_o), 0);
        check("R1 coin_en in reset", int'(coin_en_o), 1);
        do_reset();
        check("R1 status", int'(status_o), 0);
        check("R1 coin_en", int'(coin_en_o), 1);
        check("R1 dispense", int'(dispense_o), 0);

        // Exhaustive sweep: every start status x every input combination
        for (int s = 0; s < 5; s++) begin
            for (int v = 0; v < 128; v++) begin
                logic c, tk, st, cl;
                logic [2:0] sl;
                c = v[0]; sl = v[3:1]; tk = v[4]; st = v[5]; cl = v[6];
                goto_state(s);
                model(s, c, sl, tk, st, cl, ns, d, tag);
                drive(c, sl, tk, st, cl);
                check({tag, " status"}, int'(status_o), ns);
                check({tag, " dispense"}, int'(dispense_o), d);
                check("R3 coin_en", int'(coin_en_o), (ns <= 1) ? 1 : 0);
                drive(0, 0, 0, 0, 0);
                check("R12 strobe gone", int'(dispense_o), 0);
            end
        end

        // R10: credit lost across a jam
        do_reset();
        drive(1, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 1);
        check("R10 idle after clear", int'(status_o), 0);
        drive(1, 0, 0, 0, 0);
        check("R10 credit discarded", int'(status_o), 1);

        // R7: quarters ignored while waiting for the bottle
        do_reset();
        drive(1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        drive(0, 3'b100, 0, 0, 0);
        check("R4 lemon strobe", int'(dispense_o), 4);
        drive(1, 0, 0, 0, 0);
        check("R7 coin while vending", int'(status_o), 3);
        drive(1, 0, 0, 0, 0);
        check("R7 second coin while vending", int'(status_o), 3);
        drive(0, 0, 1, 0, 0);
        check("R7 taken returns idle", int'(status_o), 0);
        drive(1, 0, 0, 0, 0);
        check("R2 fresh credit after vend", int'(status_o), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule